// File: doc/BRIEF.md
# Burst Preamble and Signaling Framer

The framer produces one lane of a burst frame as a stream of 32-bit words, one word per clock, for a 32-fold serializer that sends bit 0 of each word first. A start request launches a frame. The block first emits a clock-recovery section of alternating bits. It then emits a 1024-bit training sequence. This sequence is a maximal-length sequence of 1023 bits plus one pad bit, and its starting state depends on the lane index. The third section is a signaling field of 32 words, where each captured information bit is spread by a fixed 32-chip code into a single word. Last comes the payload, which the block forwards from a valid/ready word stream until a word marked last.

Each output word carries a 2-bit section tag. Downstream logic can therefore tell training, signaling and payload apart without counting. The preamble sections are always the same and are generated inside the block, so no table is stored. The only state is a 10-bit shift register, a word counter and the held signaling bits.

Top module: `burst_framer`

## Requirements
- R1: While reset is asserted, and until the first accepted start, `out_valid_o` and `pay_ready_o` are 0.
- R2: A start request sampled high in the idle state makes the next clock cycle output the first word of the clock-recovery section. This section lasts `ANA_WORDS` words (default 32), with tag 0 and data 32'hAAAA_AAAA, so bit 0 of every word is 0.
- R3: The clock-recovery section is followed by 32 training words with tag 1. A 10-bit register is loaded with lane index + 1. Training bit a[n] for n = 0..9 is bit 9-n of that value, and for later n, a[n] = a[n-10] xor a[n-7]. This is a Fibonacci register with taps at stages 10 and 7. Word j holds a[32j+k] in bit k.
- R4: Bit 31 of the last training word is the pad bit and is always 0.
- R5: The training words are followed by 32 signaling words with tag 2. Word j carries information bit 31-j, so the most significant bit goes first. An information bit of 1 sends the spreading code (default 32'hB4E2_1D97), and a 0 sends its bitwise complement.
- R6: After the last signaling word, `pay_ready_o` is 1. Each cycle, `out_valid_o` equals `pay_valid_i`, `out_data_o` equals `pay_data_i`, and the tag is 3.
- R7: On the cycle after a payload word is accepted with `pay_last_i` high, `out_valid_o` and `pay_ready_o` are 0 again.
- R8: A start request during a frame is ignored: the section order and the section lengths stay unchanged.
- R9: Different lane indices give different training sequences, each seeded as stated in R3.
- R10: The signaling bits are captured in the start cycle. Later changes on `sig_bits_i` do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start request |
| lane_sel_i | input | LANE_W | Lane index that selects the training seed |
| sig_bits_i | input | SIG_BITS | Signaling information bits |
| pay_data_i | input | WORD_W | Payload word |
| pay_valid_i | input | 1 | Payload word valid |
| pay_last_i | input | 1 | Payload word is the last of the frame |
| pay_ready_o | output | 1 | Framer accepts payload |
| out_data_o | output | WORD_W | Output word |
| out_valid_o | output | 1 | Output word valid |
| out_sect_o | output | 2 | Section tag: 0 clock recovery, 1 training, 2 signaling, 3 payload |

## Verification
The assertions assume that the payload source holds back words until `pay_ready_o` is high. They also assume that `lane_sel_i` is stable in the start cycle, and that each frame ends with a word marked last. The stimulus meets these assumptions: it raises payload valid only in the payload section, it changes the lane only between frames, and it closes every frame with a marked word. A stalled cycle is also inserted in the payload. Start is held high through the preamble of alternate frames to exercise R8, and the signaling input is inverted right after start to exercise R10.

// File: rtl/framer_pkg.sv
package framer_pkg;
  typedef enum logic [1:0] {
    SECT_ANA = 2'd0,
    SECT_DIG = 2'd1,
    SECT_SIG = 2'd2,
    SECT_PAY = 2'd3
  } sect_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ANA,
    ST_DIG,
    ST_SIG,
    ST_PAY
  } fr_state_t;
endpackage

// File: rtl/framer_lfsr.sv
module framer_lfsr #(
  parameter int WORD_W   = 32,
  parameter int LFSR_W   = 10,
  parameter int POLY_TAP = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              adv_i,
  input  logic              last_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int TAP_IDX = POLY_TAP - 1;

  logic [LFSR_W-1:0] state_q, state_d, walk;
  logic [WORD_W-1:0] raw;

  always_comb begin
    walk = state_q;
    raw  = '0;
    for (int k = 0; k < WORD_W; k++) begin
      raw[k] = walk[LFSR_W-1];
      walk   = {walk[LFSR_W-2:0], walk[LFSR_W-1] ^ walk[TAP_IDX]};
    end
  end

  always_comb begin
    word_o = raw;
    if (last_i) word_o[WORD_W-1] = 1'b0;
  end

  always_comb begin
    state_d = state_q;
    if (load_i)     state_d = seed_i;
    else if (adv_i) state_d = walk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else if (load_i || adv_i) state_q <= state_d;
  end
endmodule

// File: rtl/framer_spreader.sv
module framer_spreader #(
  parameter int                 WORD_W   = 32,
  parameter int                 SIG_BITS = 32,
  parameter logic [WORD_W-1:0]  CODE     = 32'hB4E2_1D97
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [SIG_BITS-1:0] bits_i,
  input  logic                shift_i,
  output logic [WORD_W-1:0]   word_o
);
  logic [SIG_BITS-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load_i)       hold_d = bits_i;
    else if (shift_i) hold_d = {hold_q[SIG_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (load_i || shift_i) hold_q <= hold_d;
  end

  assign word_o = hold_q[SIG_BITS-1] ? CODE : ~CODE;
endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
#(
  parameter int ANA_WORDS = 32,
  parameter int DIG_WORDS = 32,
  parameter int SIG_WORDS = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  pay_valid_i,
  input  logic  pay_last_i,
  output logic  accept_o,
  output logic  dig_adv_o,
  output logic  dig_last_o,
  output logic  sig_shift_o,
  output logic  pay_ready_o,
  output logic  valid_o,
  output sect_t sect_o
);
  localparam int MAX_A   = (ANA_WORDS > DIG_WORDS) ? ANA_WORDS : DIG_WORDS;
  localparam int MAX_W   = (MAX_A > SIG_WORDS) ? MAX_A : SIG_WORDS;
  localparam int CNT_W   = (MAX_W > 2) ? $clog2(MAX_W) : 1;
  localparam logic [CNT_W-1:0] ANA_END = CNT_W'(ANA_WORDS - 1);
  localparam logic [CNT_W-1:0] DIG_END = CNT_W'(DIG_WORDS - 1);
  localparam logic [CNT_W-1:0] SIG_END = CNT_W'(SIG_WORDS - 1);

  fr_state_t         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q + 1'b1;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_ANA; cnt_d = '0; cnt_en = 1'b1;
      end
      ST_ANA: begin
        cnt_en = 1'b1;
        if (cnt_q == ANA_END) begin st_d = ST_DIG; cnt_d = '0; end
      end
      ST_DIG: begin
        cnt_en = 1'b1;
        if (cnt_q == DIG_END) begin st_d = ST_SIG; cnt_d = '0; end
      end
      ST_SIG: begin
        cnt_en = 1'b1;
        if (cnt_q == SIG_END) begin st_d = ST_PAY; cnt_d = '0; end
      end
      ST_PAY: if (pay_valid_i && pay_last_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign accept_o    = (st_q == ST_IDLE) && start_i;
  assign dig_adv_o   = (st_q == ST_DIG);
  assign dig_last_o  = (st_q == ST_DIG) && (cnt_q == DIG_END);
  assign sig_shift_o = (st_q == ST_SIG);
  assign pay_ready_o = (st_q == ST_PAY);

  always_comb begin
    valid_o = 1'b1;
    sect_o  = SECT_ANA;
    unique case (st_q)
      ST_IDLE: valid_o = 1'b0;
      ST_ANA:  sect_o  = SECT_ANA;
      ST_DIG:  sect_o  = SECT_DIG;
      ST_SIG:  sect_o  = SECT_SIG;
      ST_PAY:  begin sect_o = SECT_PAY; valid_o = pay_valid_i; end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/burst_framer.sv
module burst_framer
  import framer_pkg::*;
#(
  parameter int                WORD_W    = 32,
  parameter int                SIG_BITS  = 32,
  parameter int                ANA_WORDS = 32,
  parameter int                LFSR_W    = 10,
  parameter int                POLY_TAP  = 7,
  parameter int                LANE_W    = 3,
  parameter logic [WORD_W-1:0] CODE      = 32'hB4E2_1D97
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [LANE_W-1:0]   lane_sel_i,
  input  logic [SIG_BITS-1:0] sig_bits_i,
  input  logic [WORD_W-1:0]   pay_data_i,
  input  logic                pay_valid_i,
  input  logic                pay_last_i,
  output logic                pay_ready_o,
  output logic [WORD_W-1:0]   out_data_o,
  output logic                out_valid_o,
  output logic [1:0]          out_sect_o
);
  localparam int DIG_WORDS = (1 << LFSR_W) / WORD_W;
  localparam logic [WORD_W-1:0] ANA_PAT = {(WORD_W/2){2'b10}};

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic              accept, dig_adv, dig_last, sig_shift;
  sect_t             sect;
  logic [WORD_W-1:0] dig_word, sig_word;
  logic [LFSR_W-1:0] seed;

  assign seed = LFSR_W'(lane_sel_i) + LFSR_W'(1);

  framer_ctrl #(
    .ANA_WORDS(ANA_WORDS), .DIG_WORDS(DIG_WORDS), .SIG_WORDS(SIG_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .start_i(start_i),
    .pay_valid_i(pay_valid_i), .pay_last_i(pay_last_i),
    .accept_o(accept), .dig_adv_o(dig_adv), .dig_last_o(dig_last),
    .sig_shift_o(sig_shift), .pay_ready_o(pay_ready_o),
    .valid_o(out_valid_o), .sect_o(sect)
  );

  framer_lfsr #(
    .WORD_W(WORD_W), .LFSR_W(LFSR_W), .POLY_TAP(POLY_TAP)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_core_n), .load_i(accept), .seed_i(seed),
    .adv_i(dig_adv), .last_i(dig_last), .word_o(dig_word)
  );

  framer_spreader #(
    .WORD_W(WORD_W), .SIG_BITS(SIG_BITS), .CODE(CODE)
  ) u_spread (
    .clk(clk), .rst_n(rst_core_n), .load_i(accept), .bits_i(sig_bits_i),
    .shift_i(sig_shift), .word_o(sig_word)
  );

  always_comb begin
    unique case (sect)
      SECT_ANA: out_data_o = ANA_PAT;
      SECT_DIG: out_data_o = dig_word;
      SECT_SIG: out_data_o = sig_word;
      default:  out_data_o = pay_data_i;
    endcase
  end

  assign out_sect_o = sect;
endmodule

// File: rtl/framer_checker.sv
module framer_checker #(
  parameter int                WORD_W = 32,
  parameter logic [WORD_W-1:0] CODE   = 32'hB4E2_1D97
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pay_ready_o,
  input logic              pay_valid_i,
  input logic [WORD_W-1:0] out_data_o,
  input logic              out_valid_o,
  input logic [1:0]        out_sect_o
);
  logic [7:0] dig_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dig_run_q <= '0;
    else if (out_valid_o && out_sect_o == 2'd1) dig_run_q <= dig_run_q + 8'd1;
    else dig_run_q <= '0;
  end

  AST_READY_ONLY_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready_o |-> out_sect_o == 2'd3); // R6
  AST_PAY_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready_o |-> out_valid_o == pay_valid_i); // R6
  AST_ANA_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_sect_o == 2'd0) |-> out_data_o[0] == 1'b0 && out_data_o[1] == 1'b1); // R2
  AST_SIG_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_sect_o == 2'd2) |-> (out_data_o == CODE || out_data_o == ~CODE)); // R5
  AST_DIG_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    dig_run_q <= 8'd32); // R3
  AST_DIG_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_sect_o == 2'd1 && dig_run_q == 8'd31) |-> !out_data_o[WORD_W-1]); // R4
  AST_SIG_AFTER_DIG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_sect_o == 2'd2 && $past(out_valid_o) && $past(out_sect_o) != 2'd2)
      |-> $past(out_sect_o) == 2'd1); // R8
endmodule

bind burst_framer framer_checker #(.WORD_W(WORD_W), .CODE(CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pay_ready_o(pay_ready_o), .pay_valid_i(pay_valid_i),
  .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_sect_o(out_sect_o)
);

// File: tb/tb_burst_framer.sv
module tb_burst_framer;
  localparam logic [31:0] CODE = 32'hB4E2_1D97;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  lane_sel_i;
  logic [31:0] sig_bits_i;
  logic [31:0] pay_data_i;
  logic        pay_valid_i, pay_last_i;
  logic        pay_ready_o;
  logic [31:0] out_data_o;
  logic        out_valid_o;
  logic [1:0]  out_sect_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [1023:0] seq;

  always #10 clk = ~clk;

  burst_framer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lane_sel_i(lane_sel_i),
    .sig_bits_i(sig_bits_i), .pay_data_i(pay_data_i), .pay_valid_i(pay_valid_i),
    .pay_last_i(pay_last_i), .pay_ready_o(pay_ready_o), .out_data_o(out_data_o),
    .out_valid_o(out_valid_o), .out_sect_o(out_sect_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build_seq(input int lane);
    logic [9:0] seed;
    seed = 10'(lane + 1);
    for (int n = 0; n < 10; n++) seq[n] = seed[9-n];
    for (int n = 10; n < 1023; n++) seq[n] = seq[n-10] ^ seq[n-7];
    seq[1023] = 1'b0;
  endtask

  task automatic run_frame(input int lane, input logic [31:0] sig, input bit hold);
    lane_sel_i = 3'(lane);
    sig_bits_i = sig;
    build_seq(lane);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk);
    if (!hold) start_i = 1'b0;
    sig_bits_i = ~sig; // R10: must not matter
    for (int j = 0; j < 32; j++) begin
      check("R2 valid", {31'd0, out_valid_o}, 32'd1);
      check("R2 sect", {30'd0, out_sect_o}, 32'd0);
      check("R2 data", out_data_o, 32'hAAAA_AAAA);
      if (j == 0) check("R1 ready low in preamble", {31'd0, pay_ready_o}, 32'd0);
      @(negedge clk);
    end
    for (int j = 0; j < 32; j++) begin
      check("R3 sect", {30'd0, out_sect_o}, 32'd1);
      check("R3 R9 training word", out_data_o, seq[32*j +: 32]);
      if (j == 31) check("R4 pad bit", {31'd0, out_data_o[31]}, 32'd0);
      @(negedge clk);
    end
    start_i = 1'b0; // R8: held start was ignored if order intact
    for (int j = 0; j < 32; j++) begin
      check("R5 sect", {30'd0, out_sect_o}, 32'd2);
      check("R5 R10 signaling word", out_data_o, sig[31-j] ? CODE : ~CODE);
      @(negedge clk);
    end
    for (int p = 0; p < 4; p++) begin
      pay_valid_i = (p != 1);
      pay_last_i  = (p == 3);
      pay_data_i  = {8'(lane), 8'(p), sig[15:0] ^ 16'h5A5A};
      #1;
      check("R6 ready", {31'd0, pay_ready_o}, 32'd1);
      check("R6 valid", {31'd0, out_valid_o}, {31'd0, pay_valid_i});
      if (p != 1) begin
        check("R6 sect", {30'd0, out_sect_o}, 32'd3);
        check("R6 data", out_data_o, pay_data_i);
      end
      @(negedge clk);
    end
    pay_valid_i = 1'b0;
    pay_last_i  = 1'b0;
    #1;
    check("R7 idle valid", {31'd0, out_valid_o}, 32'd0);
    check("R7 idle ready", {31'd0, pay_ready_o}, 32'd0);
    @(negedge clk);
    check("R7 stays idle", {31'd0, out_valid_o}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; lane_sel_i = '0; sig_bits_i = '0;
    pay_data_i = '0; pay_valid_i = 1'b0; pay_last_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, out_valid_o}, 32'd0);
    check("R1 reset ready", {31'd0, pay_ready_o}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle valid", {31'd0, out_valid_o}, 32'd0);
    check("R1 idle ready", {31'd0, pay_ready_o}, 32'd0);
    for (int lane = 0; lane < 8; lane++) begin
      run_frame(lane, 32'h9C3E_0F51 ^ (32'h1111_1111 * lane), lane[0]);
    end
    run_frame(0, 32'hFFFF_FFFF, 1'b0);
    run_frame(7, 32'h0000_0000, 1'b1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule